// File: doc/BRIEF.md
# System-Management Interrupt Arbiter

This block merges three system-management event sources into one active-low interrupt line, `smi_n`, that goes to the processor. The three sources are:

- a trapped sleep request,
- a legacy USB request,
- a firmware-release write.

Each source has a sticky status flag. The flag only raises the interrupt when three conditions hold: its own enable bit is set, the global enable is set, and the arbiter is ready for a new assertion.

The arbiter lets the processor's handler pace the interrupts. When `smi_n` is driven low, the end-of-handler bit (`eoh`) clears itself. The line then stays low until software writes that bit back to 1. After that the line is forced high for `GAP_CYC` cycles. Only then may it fall again, and only if an enabled flag is still pending. The first assertion after reset is the one exception: it does not need `eoh`.

A lock input freezes the global enable. A sleep request that is trapped raises the interrupt and suppresses the `sleep_go` qualifier. A sleep request that is not trapped produces a one-cycle `sleep_go` pulse instead.

Top module: `smi_arbiter`

## Requirements
- R1: After reset, `smi_n` is 1, `sleep_go` is 0, and both registers read 0.
- R2: Register writes take effect at the next clock edge, and reads are combinational.
  - With `rd_sel`=0, the control register reads as follows: bit0 global enable, bit1 `eoh`, bit2 firmware-release enable, bit3 legacy-USB enable, bit4 sleep-trap enable.
  - With `rd_sel`=1, the status register reads as follows: bit0 sleep flag, bit1 USB flag, bit2 firmware flag, bits 4:3 zero.
  - `wr_sel` selects the register written, with the same encoding.
- R3: A status flag stays set until software writes 1 to that flag's bit position. If a set event and a clear arrive in the same cycle, the set wins.
- R4: While the global enable is 0, `smi_n` never falls, whatever the flags hold. A source is pending only when its flag, its own enable and the global enable are all set.
- R5: While `lock` is 1, a control write leaves the global enable unchanged but still updates the other four bits.
- R6: When `sleep_req` is strobed, the outcome depends on the sleep-trap enable:
  - With the enable at 1, the sleep flag is set and `sleep_go` stays 0.
  - With the enable at 0, `sleep_go` is 1 for exactly the next cycle and the flag is not set.
- R7: A `rel_wr` strobe sets the firmware flag whatever the enable. If that flag is already set when the firmware-release enable turns on, `smi_n` falls one cycle after the enable takes effect.
- R8: A USB request sets the USB flag, but it causes no assertion while the legacy-USB enable is 0.
- R9: The first assertion after reset happens one cycle after a source becomes pending, even with `eoh` at 0. Every assertion clears `eoh` at the same edge, and this clear overrides a simultaneous write.
- R10: Once low, `smi_n` stays low until `eoh` reads 1.
  - It then rises at the next edge and stays high for exactly `GAP_CYC` cycles.
  - It falls at the end of that window if a source is still pending and `eoh` is 1.
  - Otherwise it stays high until both conditions hold.
- R11: Every assertion after the first requires `eoh` to be 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus-rate clock |
| rst_n | input | 1 | Asynchronous active-low bus reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 status (write-1-to-clear) |
| wr_data | input | 5 | Write data |
| rd_sel | input | 1 | Read source: 0 control, 1 status |
| rd_data | output | 5 | Read data |
| lock | input | 1 | Freezes the global enable while high |
| sleep_req | input | 1 | Strobe: software wrote 1 to the sleep-enable bit |
| usb_req | input | 1 | Legacy USB event strobe |
| rel_wr | input | 1 | Strobe: software wrote 1 to the global-release bit |
| smi_n | output | 1 | Active-low system-management interrupt |
| sleep_go | output | 1 | One-cycle pulse allowing the sleep sequence |

## Verification
The assertions assume that `rst_n` is held low across at least one clock edge. They also assume that the event strobes and write controls change only between edges, so every strobe is seen as a single-cycle level. The bench drives all inputs on the falling clock edge, and it holds each strobe for exactly one cycle before clearing it. In the randomized phase, `lock` and the writes are kept sparse, so the handshake sequences complete between software actions instead of being overwritten on every cycle.

// File: rtl/smi_pkg.sv
package smi_pkg;

  localparam int CTRL_W = 5;
  localparam int STAT_W = 3;

  typedef struct packed {
    logic trap_en;
    logic usb_en;
    logic rel_en;
    logic eoh;
    logic gbl_en;
  } ctrl_t;

  typedef struct packed {
    logic rel_f;
    logic usb_f;
    logic slp_f;
  } stat_t;

  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,
    ST_LOW   = 2'd1,
    ST_GAP   = 2'd2
  } arb_st_t;

  function automatic logic any_pending(ctrl_t c, stat_t s);
    return c.gbl_en & ((s.slp_f & c.trap_en) | (s.usb_f & c.usb_en) | (s.rel_f & c.rel_en));
  endfunction

  function automatic stat_t sticky_next(stat_t cur, stat_t clr, stat_t set);
    return stat_t'((cur & ~clr) | set);
  endfunction

endpackage

// File: rtl/smi_regs.sv
module smi_regs
  import smi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              lock,
  input  logic              sleep_req,
  input  logic              usb_req,
  input  logic              rel_wr,
  input  logic              fire_i,
  output ctrl_t             ctrl_o,
  output stat_t             stat_o,
  output logic              sleep_go_o
);

  ctrl_t ctrl_q;
  stat_t stat_q;
  logic  sleep_go_q;

  logic  ctrl_wr;
  logic  stat_wr;
  stat_t clr_mask;
  stat_t set_mask;
  ctrl_t ctrl_wval;

  assign ctrl_wr  = wr_en & ~wr_sel;
  assign stat_wr  = wr_en & wr_sel;
  assign clr_mask = stat_wr ? stat_t'(wr_data[STAT_W-1:0]) : stat_t'('0);
  assign set_mask = '{rel_f: rel_wr, usb_f: usb_req, slp_f: sleep_req & ctrl_q.trap_en};

  always_comb begin
    ctrl_wval = ctrl_wr ? ctrl_t'(wr_data) : ctrl_q;
    if (lock) ctrl_wval.gbl_en = ctrl_q.gbl_en;
    if (fire_i) ctrl_wval.eoh = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      stat_q     <= '0;
      sleep_go_q <= 1'b0;
    end else begin
      ctrl_q     <= ctrl_wval;
      stat_q     <= sticky_next(stat_q, clr_mask, set_mask);
      sleep_go_q <= sleep_req & ~ctrl_q.trap_en;
    end
  end

  assign ctrl_o     = ctrl_q;
  assign stat_o     = stat_q;
  assign sleep_go_o = sleep_go_q;

  a_r5_lock_holds_gbl: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && ctrl_wr) |=> (ctrl_q.gbl_en == $past(ctrl_q.gbl_en)));

  a_r6_trap_blocks_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req && ctrl_q.trap_en) |=> (!sleep_go_q && stat_q.slp_f));

  a_r3_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q.usb_f && !(stat_wr && wr_data[1])) |=> stat_q.usb_f);

endmodule

// File: rtl/smi_gap_arb.sv
module smi_gap_arb
  import smi_pkg::*;
#(
  parameter int GAP_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pending_i,
  input  logic eoh_i,
  output logic fire_o,
  output logic smi_n_o
);

  localparam int CW = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
  localparam int HW = $clog2(GAP_CYC + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(GAP_CYC - 1);
  localparam logic [HW-1:0] HI_SAT   = HW'(GAP_CYC);

  arb_st_t       state_q;
  logic [CW-1:0] cnt_q;
  logic          first_q;
  logic          gap_end;
  logic          slot_open;

  assign gap_end   = (state_q == ST_GAP) && (cnt_q == CNT_LAST);
  assign slot_open = (state_q == ST_ARMED) || gap_end;
  assign fire_o    = slot_open && pending_i && (first_q || eoh_i);
  assign smi_n_o   = (state_q != ST_LOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_ARMED;
      cnt_q   <= '0;
      first_q <= 1'b1;
    end else begin
      if (fire_o) first_q <= 1'b0;
      unique case (state_q)
        ST_ARMED: if (fire_o) state_q <= ST_LOW;
        ST_LOW: begin
          if (eoh_i) begin
            state_q <= ST_GAP;
            cnt_q   <= '0;
          end
        end
        ST_GAP: begin
          if (gap_end) state_q <= fire_o ? ST_LOW : ST_ARMED;
          else         cnt_q   <= cnt_q + 1'b1;
        end
        default: state_q <= ST_ARMED;
      endcase
    end
  end

  // Checker state: length of the current high run and whether a low phase occurred.
  logic [HW-1:0] hi_run_q;
  logic          was_low_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run_q  <= '0;
      was_low_q <= 1'b0;
    end else begin
      if (!smi_n_o) begin
        hi_run_q  <= '0;
        was_low_q <= 1'b1;
      end else if (hi_run_q != HI_SAT) begin
        hi_run_q <= hi_run_q + 1'b1;
      end
    end
  end

  a_r10_gap_length: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_o && was_low_q) |-> (hi_run_q >= HW'(GAP_CYC - 1)));

  a_r10_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!smi_n_o && !eoh_i) |=> !smi_n_o);

  a_r11_needs_eoh: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_o && was_low_q) |-> eoh_i);

endmodule

// File: rtl/smi_arbiter.sv
module smi_arbiter
  import smi_pkg::*;
#(
  parameter int GAP_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              rd_sel,
  output logic [CTRL_W-1:0] rd_data,
  input  logic              lock,
  input  logic              sleep_req,
  input  logic              usb_req,
  input  logic              rel_wr,
  output logic              smi_n,
  output logic              sleep_go
);

  localparam int PAD_W = CTRL_W - STAT_W;

  ctrl_t ctrl;
  stat_t stat;
  logic  pending;
  logic  fire;

  smi_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .lock       (lock),
    .sleep_req  (sleep_req),
    .usb_req    (usb_req),
    .rel_wr     (rel_wr),
    .fire_i     (fire),
    .ctrl_o     (ctrl),
    .stat_o     (stat),
    .sleep_go_o (sleep_go)
  );

  assign pending = any_pending(ctrl, stat);

  smi_gap_arb #(.GAP_CYC(GAP_CYC)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .pending_i (pending),
    .eoh_i     (ctrl.eoh),
    .fire_o    (fire),
    .smi_n_o   (smi_n)
  );

  assign rd_data = rd_sel ? {{PAD_W{1'b0}}, stat} : ctrl;

  a_r4_gbl_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.gbl_en && smi_n) |=> smi_n);

  a_r9_eoh_autoclear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(smi_n) |-> !ctrl.eoh);

endmodule

// File: tb/smi_arbiter_bench.sv
`timescale 1ns/1ps
module smi_arbiter_bench;

  localparam int GAP = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [4:0] wr_data = '0;
  logic       lock = 1'b0, sleep_req = 1'b0, usb_req = 1'b0, rel_wr = 1'b0;
  logic [4:0] rd_data;
  logic       smi_n, sleep_go;

  int n_chk = 0, n_fail = 0, cyc = 0;
  string phase = "R1";

  // Behavioural reference state
  logic [4:0] m_ctl;
  logic [2:0] m_sts;
  bit         m_low, m_first, m_go;
  int         m_gapc;

  always #2.5 clk = ~clk;

  smi_arbiter #(.GAP_CYC(GAP)) u_smi_arbiter (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .lock(lock), .sleep_req(sleep_req),
    .usb_req(usb_req), .rel_wr(rel_wr), .smi_n(smi_n), .sleep_go(sleep_go)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctl = '0; m_sts = '0; m_low = 0; m_first = 1; m_go = 0; m_gapc = 0;
    end else begin
      bit pend, fire;
      logic [4:0] nctl;
      logic [2:0] clr;
      pend = m_ctl[0] && ((m_sts[0] && m_ctl[4]) || (m_sts[1] && m_ctl[3]) || (m_sts[2] && m_ctl[2]));
      fire = !m_low && (m_gapc <= 1) && pend && (m_first || m_ctl[1]);
      nctl = m_ctl;
      if (wr_en && !wr_sel) begin
        nctl = wr_data;
        if (lock) nctl[0] = m_ctl[0];
      end
      if (fire) nctl[1] = 1'b0;
      clr = (wr_en && wr_sel) ? wr_data[2:0] : 3'b000;
      m_go = sleep_req && !m_ctl[4];
      m_sts = (m_sts & ~clr) | {rel_wr, usb_req, sleep_req & m_ctl[4]};
      if (fire) begin
        m_low = 1; m_gapc = 0; m_first = 0;
      end else if (m_low && m_ctl[1]) begin
        m_low = 0; m_gapc = GAP;
      end else if (!m_low && m_gapc > 0) begin
        m_gapc--;
      end
      m_ctl = nctl;
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_model();
    chk(phase, "smi_n vs model", int'(smi_n), int'(!m_low));
    chk("R6", "sleep_go vs model", int'(sleep_go), int'(m_go));
    chk("R2", "rd_data vs model", int'(rd_data), int'(rd_sel ? {2'b00, m_sts} : m_ctl));
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare_model();
    wr_en = 0; sleep_req = 0; usb_req = 0; rel_wr = 0;
  endtask

  task automatic wctl(logic [4:0] v);
    wr_en = 1; wr_sel = 0; wr_data = v; tick();
  endtask

  task automatic wsts(logic [2:0] v);
    wr_en = 1; wr_sel = 1; wr_data = {2'b00, v}; tick();
  endtask

  task automatic rd(bit sel, output logic [4:0] v);
    rd_sel = sel; #0.5; v = rd_data;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected=<50000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [4:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    chk("R1", "smi_n after reset", int'(smi_n), 1);
    chk("R1", "sleep_go after reset", int'(sleep_go), 0);
    rd(0, v); chk("R1", "control after reset", int'(v), 0);
    rd(1, v); chk("R1", "status after reset", int'(v), 0);

    // R4 / R8: global enable off, USB flag set
    phase = "R4";
    wctl(5'b01000);
    usb_req = 1; tick();
    repeat (3) tick();
    chk("R4", "no SMI with global enable 0", int'(smi_n), 1);
    rd(1, v); chk("R3", "USB flag sticky", int'(v), 5'b00010);

    // R9 first assertion without eoh
    phase = "R9";
    wctl(5'b01001);
    tick();
    chk("R9", "first assertion without eoh", int'(smi_n), 0);
    rd(0, v); chk("R9", "eoh cleared / control", int'(v), 5'b01001);
    repeat (3) tick();
    chk("R10", "held low without eoh", int'(smi_n), 0);

    // R10 release, gap, re-arm with no pending
    phase = "R10";
    wsts(3'b010);
    wctl(5'b01011);
    tick();
    chk("R10", "rises after eoh", int'(smi_n), 1);
    repeat (4) tick();
    chk("R10", "armed and high, nothing pending", int'(smi_n), 1);
    usb_req = 1; tick();
    tick();
    chk("R11", "assertion with eoh set", int'(smi_n), 0);

    // R10 gap with source still pending
    wctl(5'b01011);
    tick();
    chk("R10", "gap cycle 1 high", int'(smi_n), 1);
    for (int i = 2; i <= GAP; i++) begin
      tick();
      chk("R10", "gap cycle high", int'(smi_n), 1);
    end
    tick();
    chk("R10", "re-assert after gap", int'(smi_n), 0);

    // R11 no assertion while eoh is 0
    phase = "R11";
    wsts(3'b010);
    wctl(5'b01011);
    tick();
    repeat (GAP) tick();
    wctl(5'b01001);
    usb_req = 1; tick();
    repeat (3) tick();
    chk("R11", "no assertion with eoh 0", int'(smi_n), 1);
    wctl(5'b01011);
    tick();
    chk("R11", "assertion once eoh set", int'(smi_n), 0);

    // R5 lock
    phase = "R5";
    lock = 1;
    wctl(5'b11110);
    lock = 0;
    rd(0, v); chk("R5", "global enable kept under lock", int'(v), 5'b11111);
    wctl(5'b00000);
    rd(0, v); chk("R5", "global enable cleared unlocked", int'(v), 5'b00000);
    wsts(3'b111);
    repeat (6) tick();

    // R6 sleep trap
    phase = "R6";
    wctl(5'b10011);
    sleep_req = 1; tick();
    chk("R6", "no sleep_go when trapped", int'(sleep_go), 0);
    rd(1, v); chk("R6", "sleep flag set when trapped", int'(v), 5'b00001);
    wsts(3'b001);
    wctl(5'b00011);
    sleep_req = 1; tick();
    chk("R6", "sleep_go pulse untrapped", int'(sleep_go), 1);
    rd(1, v); chk("R6", "no sleep flag untrapped", int'(v), 5'b00000);
    tick();
    chk("R6", "sleep_go single cycle", int'(sleep_go), 0);

    // R7 firmware release
    phase = "R7";
    repeat (8) tick();
    rel_wr = 1; tick();
    repeat (2) tick();
    chk("R7", "no SMI with release enable 0", int'(smi_n), 1);
    rd(1, v); chk("R7", "firmware flag set", int'(v), 5'b00100);
    wctl(5'b00111);
    tick();
    chk("R7", "SMI on enable with flag set", int'(smi_n), 0);

    // R3 set beats clear
    phase = "R3";
    wr_en = 1; wr_sel = 1; wr_data = 5'b00111; usb_req = 1; tick();
    rd(1, v); chk("R3", "set wins over clear", int'(v), 5'b00010);
    wsts(3'b010);
    rd(1, v); chk("R3", "write-1 clears flag", int'(v), 5'b00000);

    // Randomised traffic against the model
    phase = "R10";
    for (int i = 0; i < 2000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      rd_sel    = $urandom_range(0, 1);
      lock      = ($urandom_range(0, 9) == 0);
      usb_req   = ($urandom_range(0, 19) == 0);
      rel_wr    = ($urandom_range(0, 29) == 0);
      sleep_req = ($urandom_range(0, 29) == 0);
      if (r < 6) begin
        wr_en = 1; wr_sel = 0; wr_data = 5'($urandom_range(0, 31));
      end else if (r < 10) begin
        wr_en = 1; wr_sel = 1; wr_data = 5'($urandom_range(0, 7));
      end
      tick();
    end
    lock = 0;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule